// File: doc/BRIEF.md
# Trigger-Gated Event Framer

This block sits between an event assembly buffer and the host-bound output stream. It takes one event at a time as a stream of 32-bit channel words, throws away every word whose value is zero, and stores the rest. When the event's last word arrives it decides whether the event goes out. In local mode the event goes out at once. In global mode the event is held while a judgment window runs. The event goes out only if an external trigger pulse and a data-valid indication are both seen before that window closes. Otherwise the event is dropped and nothing of it appears at the output.

A transmitted event is framed as two header words, the kept channel words in arrival order, and two footer words. The header carries a fixed packet identifier, a running event number and a trigger time taken from a free-running timestamp input. The footer carries the board number and the number of channel words kept. The event number advances only for frames that are actually sent.

Both streams use valid/ready. An input word is taken in a cycle where `ev_valid` and `ev_ready` are both high. `ev_ready` stays low from the handshake of an event's last word until that event has been sent in full or dropped. An output word moves in a cycle where `pk_valid` and `pk_ready` are both high. While `pk_ready` is low, the offered word and its last flag do not change.

Top module: `event_gate_framer`

## Requirements
- R1: After reset `pk_valid` is low, `ev_ready` is high, and the first transmitted frame carries event number 0.
- R2: Input words equal to zero are not forwarded. Non-zero words appear in the frame payload in the order they arrived.
- R3: A frame is, in this order: word 0 = {16'hE7A5 in bits 31:16, event number in bits 15:0}; word 1 = trigger time; the payload; then board number zero-extended to 32 bits; then the kept-word count zero-extended to 32 bits. `pk_last` is high on the count word only.
- R4: With `mode_global` low when the last word is taken, the frame is sent without waiting for any trigger. Its trigger time is `ts_count` in the cycle the last word is taken.
- R5: With `mode_global` high when the last word is taken, a window of WIN_CYC cycles opens in the cycle after that handshake. The frame is sent once `glb_trig` and `data_ok` have both been seen high inside the window. They may come in either order or in the same cycle. The trigger time is `ts_count` in the first cycle inside the window where `glb_trig` is high; later triggers do not change it.
- R6: A trigger in the final window cycle (the WIN_CYC-th cycle after the last-word handshake) still counts. If the window ends without both conditions, the event is dropped: no word of it is output and `ev_ready` returns high. A trigger after the window has no effect.
- R7: A global-mode event that gets `glb_trig` but never `data_ok` in its window is dropped.
- R8: The event number increases by one for each frame sent in full and is unchanged by dropped events.
- R9: While `pk_valid` is high and `pk_ready` is low, `pk_data` and `pk_last` hold their values. `ev_ready` is low while a frame is pending or being sent.
- R10: At most DEPTH non-zero words of an event are kept (the first ones). Further non-zero words are discarded and the count word is capped at DEPTH.
- R11: `board_id` and `mode_global` are sampled at the last-word handshake. Later changes do not affect the frame being judged or sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Input word valid |
| ev_ready | output | 1 | Block can take an input word |
| ev_data | input | 32 | Channel word |
| ev_last | input | 1 | Word is the last of its event |
| board_id | input | 8 | Board number placed in the footer |
| glb_trig | input | 1 | External trigger pulse |
| data_ok | input | 1 | Data-valid indication for the judgment |
| mode_global | input | 1 | 1 = global (gated) mode, 0 = local mode |
| ts_count | input | 32 | Free-running timestamp |
| pk_valid | output | 1 | Output word valid |
| pk_ready | input | 1 | Downstream can take a word |
| pk_data | output | 32 | Framed output word |
| pk_last | output | 1 | Last word of a frame |

## Verification
A window counter that is off by one shows at the ports as a frame being kept or lost when the trigger falls exactly on the last window cycle or one cycle past it. That is visible within one window length. A slip in the event counter or in the stored count shows in the very next frame's header or footer word. A wrong trigger-time latch shows in header word 1 of the same frame. Any change to the offered word during a stall is caught in the cycle after the stall starts.

// File: rtl/egf_pkg.sv
package egf_pkg;
  typedef enum logic [1:0] {PH_FILL, PH_JUDGE, PH_SEND} phase_t;
  typedef enum logic [2:0] {SL_HID, SL_HTS, SL_PAY, SL_FBD, SL_FCT} slot_t;
endpackage

// File: rtl/egf_gather.sv
module egf_gather #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          done,
  output logic [CW-1:0] count,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          take, keep;

  assign take  = en && in_valid;
  assign keep  = take && (in_data != '0) && (cnt < CW'(DEPTH));
  assign done  = take && in_last;
  assign count = cnt;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (keep) mem[cnt[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (keep) cnt <= cnt + CW'(1);
  end

  // R10
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R2
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_data == '0 && !clr) |=> $stable(cnt));
endmodule

// File: rtl/egf_judge.sv
module egf_judge #(
  parameter int WIN = 3000,
  parameter int TW  = 32,
  localparam int CNW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          in_trig,
  input  logic          in_ok,
  input  logic [TW-1:0] ts,
  output logic          pass,
  output logic          expire,
  output logic [TW-1:0] trig_ts
);
  logic           active, trig_seen, ok_seen;
  logic [CNW-1:0] tcnt;
  logic [TW-1:0]  ts_hold;

  assign pass    = active && (trig_seen || in_trig) && (ok_seen || in_ok);
  assign expire  = active && !pass && (tcnt == CNW'(WIN - 1));
  assign trig_ts = trig_seen ? ts_hold : ts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; trig_seen <= 1'b0; ok_seen <= 1'b0;
      tcnt <= '0; ts_hold <= '0;
    end else if (arm) begin
      active <= 1'b1; trig_seen <= 1'b0; ok_seen <= 1'b0; tcnt <= '0;
    end else if (active) begin
      if (pass || expire) active <= 1'b0;
      tcnt <= tcnt + CNW'(1);
      if (in_ok) ok_seen <= 1'b1;
      if (in_trig && !trig_seen) begin
        trig_seen <= 1'b1;
        ts_hold   <= ts;
      end
    end
  end

  // R6
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (tcnt < CNW'(WIN)));
  // R5
  arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !active);
  // R5
  first_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && trig_seen && !arm) |=> $stable(ts_hold));
endmodule

// File: rtl/egf_emit.sv
module egf_emit
  import egf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] hdr0,
  input  logic [DW-1:0] hdr1,
  input  logic [DW-1:0] ftr0,
  input  logic [DW-1:0] ftr1,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_last,
  output logic          done
);
  slot_t         slot;
  logic          busy;
  logic [AW-1:0] idx;
  logic          step;

  assign step    = busy && m_ready;
  assign m_valid = busy;
  assign m_last  = busy && (slot == SL_FCT);
  assign done    = step && (slot == SL_FCT);
  assign rd_addr = idx;

  always_comb begin
    case (slot)
      SL_HID:  m_data = hdr0;
      SL_HTS:  m_data = hdr1;
      SL_PAY:  m_data = rd_data;
      SL_FBD:  m_data = ftr0;
      default: m_data = ftr1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; slot <= SL_HID; idx <= '0;
    end else if (start) begin
      busy <= 1'b1; slot <= SL_HID; idx <= '0;
    end else if (step) begin
      case (slot)
        SL_HID: slot <= SL_HTS;
        SL_HTS: slot <= (count == '0) ? SL_FBD : SL_PAY;
        SL_PAY: begin
          if ((CW'(idx) + CW'(1)) == count) slot <= SL_FBD;
          idx <= idx + AW'(1);
        end
        SL_FBD: slot <= SL_FCT;
        default: busy <= 1'b0;
      endcase
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/event_gate_framer.sv
module event_gate_framer
  import egf_pkg::*;
#(
  parameter int DW       = 32,
  parameter int BW       = 8,
  parameter int DEPTH    = 16,
  parameter int WIN_CYC  = 3000,
  parameter logic [15:0] PKT_ID = 16'hE7A5,
  localparam int HW      = DW / 2,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [DW-1:0] ev_data,
  input  logic          ev_last,
  input  logic [BW-1:0] board_id,
  input  logic          glb_trig,
  input  logic          data_ok,
  input  logic          mode_global,
  input  logic [DW-1:0] ts_count,
  output logic          pk_valid,
  input  logic          pk_ready,
  output logic [DW-1:0] pk_data,
  output logic          pk_last
);
  phase_t        phase;
  logic          fill_done, arm, pass, expire, snd_start, snd_done, clr;
  logic [CW-1:0] kept;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data, trig_ts, pkt_ts;
  logic [HW-1:0] evnum;
  logic [BW-1:0] board_q;

  assign ev_ready  = (phase == PH_FILL);
  assign arm       = fill_done && mode_global;
  assign snd_start = (fill_done && !mode_global) || ((phase == PH_JUDGE) && pass);
  assign clr       = snd_done || ((phase == PH_JUDGE) && expire);

  egf_gather #(.DW(DW), .DEPTH(DEPTH)) u_gather (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_FILL), .clr(clr),
    .in_valid(ev_valid), .in_data(ev_data), .in_last(ev_last),
    .done(fill_done), .count(kept), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  egf_judge #(.WIN(WIN_CYC), .TW(DW)) u_judge (
    .clk(clk), .rst_n(rst_n), .arm(arm), .in_trig(glb_trig), .in_ok(data_ok),
    .ts(ts_count), .pass(pass), .expire(expire), .trig_ts(trig_ts)
  );

  egf_emit #(.DW(DW), .DEPTH(DEPTH)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(snd_start),
    .hdr0({PKT_ID[HW-1:0], evnum}), .hdr1(pkt_ts),
    .ftr0(DW'(board_q)), .ftr1(DW'(kept)), .count(kept),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .m_valid(pk_valid), .m_ready(pk_ready), .m_data(pk_data),
    .m_last(pk_last), .done(snd_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FILL; evnum <= '0; pkt_ts <= '0; board_q <= '0;
    end else begin
      case (phase)
        PH_FILL: if (fill_done) begin
          board_q <= board_id;
          if (mode_global) phase <= PH_JUDGE;
          else begin
            phase  <= PH_SEND;
            pkt_ts <= ts_count;
          end
        end
        PH_JUDGE: if (pass) begin
          phase  <= PH_SEND;
          pkt_ts <= trig_ts;
        end else if (expire) phase <= PH_FILL;
        default: if (snd_done) begin
          phase <= PH_FILL;
          evnum <= evnum + HW'(1);
        end
      endcase
    end
  end

  // R8
  evnum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_done |=> $stable(evnum));
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid |-> !ev_ready);
  // R6
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_JUDGE) && expire) |=> (!pk_valid && ev_ready));
  // R11
  board_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_FILL) |=> $stable(board_q));
endmodule

// File: tb/event_gate_framer_test.sv
module event_gate_framer_test;
  localparam int DEPTH = 16;
  localparam int WIN   = 3000;
  localparam logic [15:0] PID = 16'hE7A5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ev_valid, ev_ready, ev_last, glb_trig, data_ok, mode_global;
  logic pk_valid, pk_ready, pk_last;
  logic [31:0] ev_data, ts_count, pk_data;
  logic [7:0]  board_id;

  event_gate_framer uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_data(ev_data), .ev_last(ev_last), .board_id(board_id),
    .glb_trig(glb_trig), .data_ok(data_ok), .mode_global(mode_global),
    .ts_count(ts_count), .pk_valid(pk_valid), .pk_ready(pk_ready),
    .pk_data(pk_data), .pk_last(pk_last)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] rx_q[$];
  logic [31:0] exp_q[$];
  bit  rx_done = 0;
  bit  bp_en = 0;
  logic [15:0] exp_ev = '0;
  bit  hold_v = 0;
  logic [31:0] hold_d;
  logic hold_l;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // output monitor: drives ready, records handshakes, checks stall holding (R9)
  initial begin
    pk_ready = 1'b0;
    forever begin
      @(negedge clk);
      pk_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (hold_v && rst_n) begin
        chk("R9 stall data", pk_data, hold_d);
        chk("R9 stall last", {31'b0, pk_last}, {31'b0, hold_l});
      end
      hold_v = pk_valid && !pk_ready;
      hold_d = pk_data;
      hold_l = pk_last;
      if (pk_valid && pk_ready) begin
        rx_q.push_back(pk_data);
        if (pk_last) rx_done = 1;
      end
    end
  end

  function automatic void build(input logic [31:0] w[$], input logic [31:0] ts,
                                input logic [7:0] bd);
    int n = 0;
    exp_q.delete();
    exp_q.push_back({PID, exp_ev});
    exp_q.push_back(ts);
    foreach (w[i]) if (w[i] != 0 && n < DEPTH) begin
      exp_q.push_back(w[i]);
      n++;
    end
    exp_q.push_back({24'b0, bd});
    exp_q.push_back(32'(n));
  endfunction

  task automatic cmp_frame();
    chk("R3 frame length", 32'(rx_q.size()), 32'(exp_q.size()));
    if (rx_q.size() == exp_q.size())
      foreach (exp_q[i]) begin
        if (i == 0)                    chk("R8 header event number", rx_q[i], exp_q[i]);
        else if (i == 1)               chk("R5 R4 trigger time", rx_q[i], exp_q[i]);
        else if (i == exp_q.size()-1)  chk("R10 kept count", rx_q[i], exp_q[i]);
        else if (i == exp_q.size()-2)  chk("R11 board word", rx_q[i], exp_q[i]);
        else                           chk("R2 payload", rx_q[i], exp_q[i]);
      end
    rx_q.delete();
    rx_done = 0;
  endtask

  task automatic wait_frame();
    int t = 0;
    while (!rx_done && t < 3000) begin
      @(posedge clk);
      t++;
    end
    @(negedge clk); #1;
  endtask

  task automatic send_event(input logic [31:0] w[$], input bit gm,
                            input logic [7:0] bd, input logic [31:0] tsv);
    foreach (w[i]) begin
      @(negedge clk);
      ev_valid = 1'b1; ev_data = w[i]; ev_last = (i == w.size()-1);
      mode_global = gm; board_id = bd;
      ts_count = (i == w.size()-1) ? tsv : $urandom;
      #1;
      while (!ev_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
  endtask

  task automatic run_local(input logic [31:0] w[$], input logic [7:0] bd,
                           input logic [31:0] tsv);
    send_event(w, 1'b0, bd, tsv);
    @(negedge clk);
    ev_valid = 1'b0; mode_global = 1'b1; board_id = ~bd; ts_count = ~tsv;
    #1 chk("R9 ev_ready low while pending", {31'b0, ev_ready}, 32'd0);
    wait_frame();
    build(w, tsv, bd);
    exp_ev++;
    cmp_frame();
  endtask

  task automatic run_global(input logic [31:0] w[$], input logic [7:0] bd,
                            input int trig_d, input int trig2_d, input int ok_d,
                            input logic [31:0] tsv, input bit pass);
    int maxd;
    maxd = trig_d;
    if (trig2_d > maxd) maxd = trig2_d;
    if (ok_d > maxd) maxd = ok_d;
    send_event(w, 1'b1, bd, tsv ^ 32'hFFFF_0000);
    for (int d = 1; d <= maxd; d++) begin
      @(negedge clk);
      ev_valid = 1'b0; mode_global = 1'b0; board_id = ~bd;
      glb_trig = (d == trig_d) || (d == trig2_d);
      data_ok  = (d == ok_d);
      ts_count = (d == trig_d) ? tsv : (d == trig2_d) ? (tsv ^ 32'h00FF_00FF) : $urandom;
      if (d == 1) #1 chk("R9 ev_ready low in window", {31'b0, ev_ready}, 32'd0);
      @(posedge clk);
    end
    @(negedge clk);
    ev_valid = 1'b0; glb_trig = 1'b0; data_ok = 1'b0; mode_global = 1'b0;
    if (pass) begin
      wait_frame();
      build(w, tsv, bd);
      exp_ev++;
      cmp_frame();
    end else begin
      repeat (WIN + 4) @(posedge clk);
      @(negedge clk); #1;
      chk("R6 R7 dropped event emits nothing", 32'(rx_q.size()), 32'd0);
      chk("R6 ev_ready back after drop", {31'b0, ev_ready}, 32'd1);
      rx_q.delete(); rx_done = 0;
    end
  endtask

  function automatic void rand_words(ref logic [31:0] w[$], input int n);
    w.delete();
    for (int i = 0; i < n; i++) w.push_back((($urandom % 3) == 0) ? 32'd0 : ($urandom | 32'd1));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w[$];
    void'($urandom(32'd4242));
    rst_n = 0; ev_valid = 0; ev_data = 0; ev_last = 0; board_id = 0;
    glb_trig = 0; data_ok = 0; mode_global = 0; ts_count = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 pk_valid after reset", {31'b0, pk_valid}, 32'd0);
    chk("R1 ev_ready after reset", {31'b0, ev_ready}, 32'd1);

    // R1 R4: first local frame, event number 0, zeros removed (R2)
    w = '{32'h11, 32'h0, 32'h22, 32'h0, 32'h33};
    run_local(w, 8'h5A, 32'hCAFE_0001);
    // R2: all-zero event yields empty payload and count 0
    w = '{32'h0, 32'h0};
    run_local(w, 8'h01, 32'h0000_0777);
    // R10: overflow beyond DEPTH non-zero words
    w.delete();
    for (int i = 1; i <= DEPTH + 4; i++) w.push_back(32'(i * 3));
    bp_en = 1;
    run_local(w, 8'hC3, 32'h1234_5678);
    // R5: same-cycle trigger and ok
    w = '{32'hAA, 32'hBB};
    run_global(w, 8'h22, 7, 0, 7, 32'hBEEF_0007, 1'b1);
    // R5: ok first, trigger later; then trigger first, ok later with second trigger
    run_global(w, 8'h23, 40, 0, 3, 32'hBEEF_0040, 1'b1);
    run_global(w, 8'h24, 5, 12, 20, 32'hBEEF_0005, 1'b1);
    // R7: trigger without ok -> dropped, event number unchanged
    run_global(w, 8'h25, 10, 0, 0, 32'h0, 1'b0);
    // R6: trigger in final window cycle counts
    run_global(w, 8'h26, WIN, 0, WIN / 2, 32'hFEED_0BB8, 1'b1);
    // R6: trigger one cycle past the window -> dropped
    run_global(w, 8'h27, WIN + 1, 0, WIN / 2, 32'h0, 1'b0);

    // random mix (R2 R4 R5 R8 R9 R11)
    for (int k = 0; k < 40; k++) begin
      int n;
      n = 1 + ($urandom % 10);
      rand_words(w, n);
      bp_en = ($urandom % 2) == 1;
      if (($urandom % 2) == 0)
        run_local(w, 8'($urandom), $urandom);
      else if (($urandom % 6) == 0)
        run_global(w, 8'($urandom), 1 + ($urandom % 50), 0, 0, 32'h0, 1'b0);
      else
        run_global(w, 8'($urandom), 1 + ($urandom % 80), 0, 1 + ($urandom % 80),
                   $urandom, 1'b1);
    end

    // R8: final local frame confirms running event number
    w = '{32'h0, 32'h9};
    run_local(w, 8'h7E, 32'h0BAD_F00D);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule